// File: doc/BRIEF.md
# Daisy-Chained Serial DAC Frame Writer

This block runs on the host side and loads a string of 10-bit serial converters that are wired output-to-input. A one-cycle `start` pulse captures one code per converter from the flat `codes` bus. Each code becomes a 16-bit word: four zero pad bits on top, the ten code bits most significant first, and two zero bits below. The words are joined into one frame. The word for the converter farthest down the string goes first. The whole frame is shifted out under a single low period of the select line.

The serial lines use clock-idle-low timing. Data changes on falling clock edges and is taken on rising ones. Each clock phase lasts `CLK_DIV` system clocks. Select moves only while the serial clock is low, and it stays high for `CS_GAP` system clocks before `done` is raised.

While the frame shifts out, the block samples the far end of the string on every rising edge. When `CHECK_EN` is set, it compares that returned stream with the frame it sent the time before, so the host can confirm the converters took the previous load. `start`, `busy`, `done` and `mismatch` are plain control and status pins. The block has no data stream needing back-pressure: it takes the code bus only in the cycle `start` is accepted, and it ignores `start` while busy.

Top module: `dac_chain_writer`

## Requirements
- R1: Each converter word is 16 bits, sent most significant bit first. Bits 15..12 are zero, bits 11..2 carry that converter's 10-bit code, and bits 1..0 are zero.
- R2: Converter k takes its code from `codes[10k+9:10k]`. Converter 0 is the one whose input is `mosi`. The frame sends converter N_DEV-1's word first and converter 0's word last, so after the frame every converter holds its own word.
- R3: `sclk` is low in every cycle where `cs_n` is high. `cs_n` changes only when `sclk` is low both in the cycle before the change and in the cycle of the change.
- R4: Within a frame, every high phase of `sclk` lasts exactly CLK_DIV cycles. Every low phase lasts at least CLK_DIV cycles, including the phase after `cs_n` falls and the phase before it rises.
- R5: `mosi` never changes while `sclk` is high, and never in the cycle `sclk` rises.
- R6: One frame holds exactly 16×N_DEV rising `sclk` edges.
- R7: `done` goes high once `cs_n` has been high for exactly CS_GAP cycles after the frame. `busy` is low in that same cycle.
- R8: A `start` seen while `busy` is low begins a frame: in the next cycle `busy` is high and `cs_n` is low. A `start` seen while `busy` is high has no effect on the frame in progress and does not queue a later frame.
- R9: `mismatch` updates when `cs_n` rises. It reads 1 only when a previous frame exists and the 16×N_DEV bits sampled from `miso` on this frame's rising edges differ from that previous frame. Otherwise it reads 0.
- R10: During and right after reset, `cs_n` is 1, and `sclk`, `busy`, `done` and `mismatch` are 0.
- R11: `done` is high for exactly one system clock per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame; taken only when idle |
| codes | input | 10×N_DEV | One 10-bit code per converter, converter k at bits 10k+9..10k |
| busy | output | 1 | High from the cycle after accepted start until done |
| done | output | 1 | One-cycle pulse at the end of the select-high gap |
| mismatch | output | 1 | Readback differed from the previous frame |
| cs_n | output | 1 | Active-low select for the converter string |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data toward converter 0 |
| miso | input | 1 | Serial data returned from the last converter |

## Verification
Select falls, and `busy` rises, one system clock after an accepted `start`. The first rising `sclk` comes CLK_DIV clocks later. `mismatch` is settled from the cycle `cs_n` rises, and `done` follows exactly CS_GAP clocks after that rise. The bench drives on falling system-clock edges and samples every output on falling edges. It counts phase lengths and gap lengths sample by sample and compares them with those cycle counts. It checks `mismatch` only once `done` arrives. A behavioural model of the converter string feeds `miso`, and a scoreboard compares each converter's latched word with the queued codes when `cs_n` rises.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int CODE_W = 10;
  localparam int PAD_HI = 4;
  localparam int PAD_LO = 2;
  localparam int WORD_W = PAD_HI + CODE_W + PAD_LO;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_GAP
  } wr_state_e;

  function automatic logic [WORD_W-1:0] make_word(input logic [CODE_W-1:0] code);
    return {{PAD_HI{1'b0}}, code, {PAD_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/dacw_framer.sv
module dacw_framer
  import dacw_pkg::*;
#(
  parameter int N_DEV = 2,
  localparam int FRAME_W = WORD_W * N_DEV
) (
  input  logic [CODE_W*N_DEV-1:0] codes,
  output logic [FRAME_W-1:0]      frame
);
  // Converter N_DEV-1 occupies the top word and therefore leaves first.
  for (genvar g = 0; g < N_DEV; g++) begin : g_word
    assign frame[g*WORD_W +: WORD_W] = make_word(codes[g*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/dacw_sequencer.sv
module dacw_sequencer
  import dacw_pkg::*;
#(
  parameter int N_DEV   = 2,
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 3,
  localparam int FRAME_W = WORD_W * N_DEV,
  localparam int BIT_W   = $clog2(FRAME_W),
  localparam int CNT_MAX = (CLK_DIV > CS_GAP) ? CLK_DIV : CS_GAP,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               busy,
  output logic               done,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  output logic               rise_stb,
  output logic               end_stb,
  output logic [FRAME_W-1:0] sent_frame
);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(CS_GAP - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  wr_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic [FRAME_W-1:0] shift_q;
  logic [FRAME_W-1:0] frame_q;
  logic               phase_end;

  assign phase_end  = (cnt == DIV_LAST);
  assign busy       = (state != ST_IDLE);
  assign rise_stb   = ((state == ST_LEAD) || (state == ST_LOW)) && phase_end;
  assign end_stb    = (state == ST_TAIL) && phase_end;
  assign sent_frame = frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shift_q <= '0;
      frame_q <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            frame_q <= frame_in;
            shift_q <= frame_in;
            mosi    <= frame_in[FRAME_W-1];
            cs_n    <= 1'b0;
            cnt     <= '0;
            bit_idx <= '0;
            state   <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (phase_end) begin
            cnt   <= '0;
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (bit_idx == BIT_LAST) begin
              state <= ST_TAIL;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
              mosi    <= shift_q[FRAME_W-2];
              state   <= ST_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (phase_end) begin
            cnt   <= '0;
            cs_n  <= 1'b1;
            state <= ST_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == GAP_LAST) begin
            cnt   <= '0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacw_readback.sv
module dacw_readback
  import dacw_pkg::*;
#(
  parameter int N_DEV    = 2,
  parameter bit CHECK_EN = 1'b1,
  localparam int FRAME_W = WORD_W * N_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_stb,
  input  logic               end_stb,
  input  logic               miso,
  input  logic [FRAME_W-1:0] sent_frame,
  output logic               mismatch
);
  if (CHECK_EN) begin : g_check
    logic [FRAME_W-1:0] rx_q;
    logic [FRAME_W-1:0] prev_q;
    logic               have_prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_q      <= '0;
        prev_q    <= '0;
        have_prev <= 1'b0;
        mismatch  <= 1'b0;
      end else begin
        if (rise_stb) rx_q <= {rx_q[FRAME_W-2:0], miso};
        if (end_stb) begin
          mismatch  <= have_prev && (rx_q != prev_q);
          prev_q    <= sent_frame;
          have_prev <= 1'b1;
        end
      end
    end
  end else begin : g_nocheck
    assign mismatch = 1'b0;
  end
endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
  import dacw_pkg::*;
#(
  parameter int N_DEV    = 2,
  parameter int CLK_DIV  = 2,
  parameter int CS_GAP   = 3,
  parameter bit CHECK_EN = 1'b1,
  localparam int FRAME_W = WORD_W * N_DEV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CODE_W*N_DEV-1:0] codes,
  output logic                    busy,
  output logic                    done,
  output logic                    mismatch,
  output logic                    cs_n,
  output logic                    sclk,
  output logic                    mosi,
  input  logic                    miso
);
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] sent_frame;
  logic               rise_stb;
  logic               end_stb;

  dacw_framer #(.N_DEV(N_DEV)) u_framer (
    .codes (codes),
    .frame (frame)
  );

  dacw_sequencer #(.N_DEV(N_DEV), .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .frame_in   (frame),
    .busy       (busy),
    .done       (done),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .mosi       (mosi),
    .rise_stb   (rise_stb),
    .end_stb    (end_stb),
    .sent_frame (sent_frame)
  );

  dacw_readback #(.N_DEV(N_DEV), .CHECK_EN(CHECK_EN)) u_rb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_stb   (rise_stb),
    .end_stb    (end_stb),
    .miso       (miso),
    .sent_frame (sent_frame),
    .mismatch   (mismatch)
  );
endmodule

// File: rtl/dac_chain_writer_chk.sv
module dac_chain_writer_chk #(
  parameter int CLK_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= sclk ? hi_run + 16'd1 : 16'd0;
  end

  AST_CLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R3
  AST_SELECT_MOVES_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> (!sclk && !$past(sclk))); // R3
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == 16'(CLK_DIV))); // R4
  AST_DATA_STABLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R5
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n)); // R7
  AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !cs_n)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
endmodule

bind dac_chain_writer dac_chain_writer_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .cs_n  (cs_n),
  .sclk  (sclk),
  .mosi  (mosi)
);

// File: tb/dac_chain_writer_bench.sv
module dac_chain_writer_bench;
  localparam int N   = 2;
  localparam int DIV = 2;
  localparam int GAP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N*10-1:0] codes = '0;
  logic          busy, done, mismatch, cs_n, sclk, mosi, miso;
  logic          inject = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  dac_chain_writer #(.N_DEV(N), .CLK_DIV(DIV), .CS_GAP(GAP), .CHECK_EN(1'b1)) u_dac_chain_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .codes(codes), .busy(busy), .done(done),
    .mismatch(mismatch), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural converter string: shift on rising sclk, pass on at falling sclk.
  logic [15:0] sr [N];
  logic        dout [N];
  initial for (int i = 0; i < N; i++) begin sr[i] = '0; dout[i] = 1'b0; end

  always @(posedge sclk) if (!cs_n) begin
    for (int i = 0; i < N; i++) sr[i] <= {sr[i][14:0], (i == 0) ? mosi : dout[i-1]};
  end
  always @(negedge sclk) if (!cs_n) begin
    for (int i = 0; i < N; i++) dout[i] <= sr[i][15];
  end
  assign miso = dout[N-1] ^ inject;

  // Scoreboard: driver queues codes, monitor compares on select rise.
  logic [N*10-1:0] sb_q [$];
  always @(posedge cs_n) if (rst_n && sb_q.size() > 0) begin
    logic [N*10-1:0] e;
    e = sb_q.pop_front();
    for (int i = 0; i < N; i++) begin
      chk(sr[i][11:2] == e[i*10 +: 10], "R2", $sformatf("dev%0d code", i), sr[i][11:2], e[i*10 +: 10]);
      chk(sr[i][15:12] == 4'd0 && sr[i][1:0] == 2'd0, "R1", $sformatf("dev%0d pad bits", i),
          {sr[i][15:12], sr[i][1:0]}, 0);
    end
  end

  // Timing monitor, sampled on falling system-clock edges.
  int hi_run = 0, lo_run = 0, rises = 0, gap_run = 0;
  bit phase_bad = 0, cs_bad = 0, p_sclk = 0, p_cs = 1;
  always @(negedge clk) if (rst_n) begin
    if (p_cs && !cs_n) begin lo_run = 0; rises = 0; phase_bad = 0; cs_bad = 0; end
    if (cs_n != p_cs && (sclk || p_sclk)) cs_bad = 1;
    if (cs_n && sclk) cs_bad = 1;
    if (!cs_n) begin
      if (sclk) begin
        if (!p_sclk) begin rises++; if (lo_run < DIV) phase_bad = 1; hi_run = 1; end
        else hi_run++;
      end else begin
        if (p_sclk) begin if (hi_run != DIV) phase_bad = 1; lo_run = 1; end
        else lo_run++;
      end
    end
    if (!p_cs && cs_n) begin
      chk(rises == 16*N, "R6", "rising edges per frame", rises, 16*N);
      chk(!phase_bad && lo_run >= DIV, "R4", "phase lengths", lo_run, DIV);
      chk(!cs_bad, "R3", "select/clock relation", cs_bad, 0);
      gap_run = 1;
    end else if (cs_n && !done) gap_run++;
    p_sclk = sclk;
    p_cs   = cs_n;
  end

  task automatic run_frame(input logic [N*10-1:0] c, input bit inj, input bit exp_mis, input bit poke);
    @(negedge clk);
    codes  = c;
    inject = inj;
    sb_q.push_back(c);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    chk(busy && !cs_n, "R8", "frame opens after start", {busy, cs_n}, 2);
    if (poke) begin
      repeat (20) @(negedge clk);
      codes = ~c;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(gap_run == GAP, "R7", "select-high cycles before done", gap_run, GAP);
    chk(!busy, "R7", "busy low with done", busy, 0);
    chk(mismatch == exp_mis, "R9", "readback flag", mismatch, exp_mis);
    @(negedge clk);
    chk(!done, "R11", "done width", done, 0);
    inject = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !mismatch, "R10", "outputs in reset",
        {cs_n, sclk, busy, done, mismatch}, 16);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !mismatch, "R10", "outputs after reset",
        {cs_n, sclk, busy, done, mismatch}, 16);
    // R1 R2 extremes: full scale far, zero near; first frame has no readback (R9)
    run_frame({10'h3FF, 10'h000}, 1'b0, 1'b0, 1'b0);
    run_frame({10'h155, 10'h2AA}, 1'b0, 1'b0, 1'b0);
    // R9 corrupted return stream
    run_frame({10'h001, 10'h200}, 1'b1, 1'b1, 1'b0);
    run_frame({10'h3FE, 10'h3FF}, 1'b0, 1'b0, 1'b0);
    // R8 start during a frame is ignored
    run_frame({10'h0F0, 10'h30F}, 1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk(cs_n && !busy, "R8", "no frame from ignored start", {cs_n, busy}, 2);
    chk(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule